// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block turns the synchronized input levels of a 32-pin GPIO bank into one interrupt line. Each pin has its own configuration. An enable bit lets the pin record detections at all. A sense bit picks edge or level detection. A polarity bit picks the rising/high or the falling/low sense. An any-edge bit makes the pin fire on every transition, so software does not have to flip the polarity after each event. A mask bit hides the pin from the interrupt output but keeps it visible in the raw status.

The configuration is written through a register bus in which every 32-bit register is split into two half-word words. The low 16 bits of the write data carry the new values. The high 16 bits carry per-bit write enables, so a single pin can be changed without a read-modify-write. Edge detections are held until an end-of-interrupt write clears them. Level detections follow the pin and cannot be cleared that way. The output is the registered OR of the unmasked status bits.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every configuration register, both status views and `irq_out` read 0.
- R2: A write to offset A updates pins 0-15 of the register at A, and a write to A+4 updates pins 16-31. Within the half, bit b takes data bit b only where data bit 16+b is 1; all other bits keep their value. A read of A or A+4 returns that half in bits 15:0 with bits 31:16 at 0. Base offsets: enable 0x10, mask 0x18, sense 0x20, polarity 0x28, any-edge 0x30, status 0x50 (read only), raw status 0x58 (read only), end-of-interrupt 0x60 (write only, reads 0). Any other address, or one with bits 1:0 non-zero, reads 0 and ignores writes.
- R3: An enabled pin with sense 1 (edge), polarity 1 and any-edge 0 latches its raw bit at the clock edge that first samples the pin high after it was sampled low.
- R4: With sense 1, polarity 0 and any-edge 0, the raw bit latches on a high-to-low transition and ignores rising ones.
- R5: With any-edge 1, both transitions latch the raw bit, whatever the sense and polarity bits hold.
- R6: With sense 0 and any-edge 0, the raw bit equals (pin == polarity) as sampled at the previous clock edge. It is not latched.
- R7: Writing 1 to an end-of-interrupt bit, with its write-enable bit set, clears that pin's latched edge at that clock edge. Without the write-enable bit the write has no effect. It has no effect on a level-mode pin. A new edge in the same cycle keeps the bit set.
- R8: A pin whose enable is 0 records nothing, and clearing the enable drops its raw bit at the next edge.
- R9: Raw status ignores the mask. Status equals raw status with the masked pins forced to 0.
- R10: `irq_out` is high in the cycle after any status bit was high, and low in the cycle after none was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 32 | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data: values in 15:0, write enables in 31:16 |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
On every cycle the assertions check four things. Level-mode pins mirror the previous pin sample. Any-edge pins latch on every transition. Disabled pins stay quiet. The interrupt line follows the OR of the status one cycle late. They also check that a low-half enable write merges bits exactly as its write-enable lanes dictate. The bench's scenarios show the rest: the exclusive rising or falling sense, how the end-of-interrupt write interacts with a same-cycle edge and with level pins, the status-versus-raw split under the mask, and the read-back of each half. A random phase with concurrent configuration writes and pin toggles is compared against a behavioural model on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register base offsets; bit 2 of an address selects the upper half-word.
  localparam logic [7:0] OFS_ENABLE = 8'h10;
  localparam logic [7:0] OFS_MASK   = 8'h18;
  localparam logic [7:0] OFS_SENSE  = 8'h20;
  localparam logic [7:0] OFS_POLAR  = 8'h28;
  localparam logic [7:0] OFS_ANYEDG = 8'h30;
  localparam logic [7:0] OFS_STATUS = 8'h50;
  localparam logic [7:0] OFS_RAW    = 8'h58;
  localparam logic [7:0] OFS_ACK    = 8'h60;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ENABLE, SEL_MASK, SEL_SENSE, SEL_POLAR, SEL_ANYEDG
  } cfg_sel_e;

endpackage

// File: rtl/gpio_irq_regfile.sv
module gpio_irq_regfile
  import gpio_irq_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 8,
  localparam int NPINS = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic [NPINS-1:0]  raw_in,
  input  logic [NPINS-1:0]  status_in,
  output logic [NPINS-1:0]  bus_rdata,
  output logic [NPINS-1:0]  en_q,
  output logic [NPINS-1:0]  msk_q,
  output logic [NPINS-1:0]  edg_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  any_q,
  output logic [NPINS-1:0]  ack_pulse
);

  logic [ADDR_W-1:0] base;
  logic              hi_half;
  logic              aligned;
  cfg_sel_e          wsel;
  logic              cfg_we;
  logic [NPINS-1:0]  en_d, msk_d, edg_d, pol_d, any_d;
  logic [NPINS-1:0]  rd_word;

  // Merge one half-word lane set into the current register value.
  function automatic logic [NPINS-1:0] lane_merge(input logic [NPINS-1:0] cur,
                                                  input logic [NPINS-1:0] wd,
                                                  input logic             hi);
    logic [NPINS-1:0] res;
    res = cur;
    for (int b = 0; b < HALF_W; b++) begin
      if (wd[HALF_W+b]) res[(hi ? HALF_W : 0) + b] = wd[b];
    end
    return res;
  endfunction

  function automatic logic [NPINS-1:0] ack_bits(input logic [NPINS-1:0] wd,
                                                input logic             hi);
    logic [NPINS-1:0] res;
    res = '0;
    for (int b = 0; b < HALF_W; b++) begin
      res[(hi ? HALF_W : 0) + b] = wd[HALF_W+b] & wd[b];
    end
    return res;
  endfunction

  assign base    = {bus_addr[ADDR_W-1:3], 3'b000};
  assign hi_half = bus_addr[2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  // Write decode
  always_comb begin
    wsel = SEL_NONE;
    if (aligned) begin
      if      (base == ADDR_W'(OFS_ENABLE)) wsel = SEL_ENABLE;
      else if (base == ADDR_W'(OFS_MASK))   wsel = SEL_MASK;
      else if (base == ADDR_W'(OFS_SENSE))  wsel = SEL_SENSE;
      else if (base == ADDR_W'(OFS_POLAR))  wsel = SEL_POLAR;
      else if (base == ADDR_W'(OFS_ANYEDG)) wsel = SEL_ANYEDG;
    end
  end

  assign cfg_we = bus_wr && (wsel != SEL_NONE);

  // Next-state
  always_comb begin
    en_d  = en_q;
    msk_d = msk_q;
    edg_d = edg_q;
    pol_d = pol_q;
    any_d = any_q;
    unique case (wsel)
      SEL_ENABLE: en_d  = lane_merge(en_q,  bus_wdata, hi_half);
      SEL_MASK:   msk_d = lane_merge(msk_q, bus_wdata, hi_half);
      SEL_SENSE:  edg_d = lane_merge(edg_q, bus_wdata, hi_half);
      SEL_POLAR:  pol_d = lane_merge(pol_q, bus_wdata, hi_half);
      SEL_ANYEDG: any_d = lane_merge(any_q, bus_wdata, hi_half);
      default: ;
    endcase
  end

  always_comb begin
    ack_pulse = '0;
    if (bus_wr && aligned && (base == ADDR_W'(OFS_ACK)))
      ack_pulse = ack_bits(bus_wdata, hi_half);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      msk_q <= '0;
      edg_q <= '0;
      pol_q <= '0;
      any_q <= '0;
    end else if (cfg_we) begin
      en_q  <= en_d;
      msk_q <= msk_d;
      edg_q <= edg_d;
      pol_q <= pol_d;
      any_q <= any_d;
    end
  end

  // Read mux
  always_comb begin
    rd_word = '0;
    if (aligned) begin
      if      (base == ADDR_W'(OFS_ENABLE)) rd_word = en_q;
      else if (base == ADDR_W'(OFS_MASK))   rd_word = msk_q;
      else if (base == ADDR_W'(OFS_SENSE))  rd_word = edg_q;
      else if (base == ADDR_W'(OFS_POLAR))  rd_word = pol_q;
      else if (base == ADDR_W'(OFS_ANYEDG)) rd_word = any_q;
      else if (base == ADDR_W'(OFS_STATUS)) rd_word = status_in;
      else if (base == ADDR_W'(OFS_RAW))    rd_word = raw_in;
    end
    bus_rdata = {{HALF_W{1'b0}},
                 hi_half ? rd_word[NPINS-1:HALF_W] : rd_word[HALF_W-1:0]};
  end

endmodule

// File: rtl/gpio_irq_pin_cell.sv
module gpio_irq_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic en,
  input  logic edg,
  input  logic pol,
  input  logic any,
  input  logic ack,
  output logic raw_o
);

  logic prev_q, raw_q, raw_d;
  logic rise, fall, hit, edge_mode;

  always_comb begin
    rise      = pin & ~prev_q;
    fall      = ~pin & prev_q;
    edge_mode = edg | any;
    hit       = any ? (rise | fall) : (pol ? rise : fall);
    if (!en)
      raw_d = 1'b0;
    else if (edge_mode)
      raw_d = (raw_q & ~ack) | hit;
    else
      raw_d = (pin == pol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= pin;
      raw_q  <= raw_d;
    end
  end

  assign raw_o = raw_q;

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw,
  input  logic [NPINS-1:0] msk,
  output logic [NPINS-1:0] status,
  output logic             irq
);

  logic irq_q, irq_d;

  assign status = raw & ~msk;

  always_comb irq_d = |status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 8,
  localparam int NPINS = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq_out
);

  logic [NPINS-1:0] en_q, msk_q, edg_q, pol_q, any_q, ack_pulse;
  logic [NPINS-1:0] raw_w, status_w;

  gpio_irq_regfile #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .raw_in    (raw_w),
    .status_in (status_w),
    .bus_rdata (bus_rdata),
    .en_q      (en_q),
    .msk_q     (msk_q),
    .edg_q     (edg_q),
    .pol_q     (pol_q),
    .any_q     (any_q),
    .ack_pulse (ack_pulse)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_irq_pin_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (pin_lvl[p]),
      .en    (en_q[p]),
      .edg   (edg_q[p]),
      .pol   (pol_q[p]),
      .any   (any_q[p]),
      .ack   (ack_pulse[p]),
      .raw_o (raw_w[p])
    );
  end

  gpio_irq_combine #(.NPINS(NPINS)) u_comb (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (raw_w),
    .msk    (msk_q),
    .status (status_w),
    .irq    (irq_out)
  );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pin_lvl,
  input logic [NPINS-1:0]  en,
  input logic [NPINS-1:0]  edg,
  input logic [NPINS-1:0]  pol,
  input logic [NPINS-1:0]  any,
  input logic [NPINS-1:0]  raw,
  input logic [NPINS-1:0]  status,
  input logic              irq_out
);

  localparam int H = NPINS / 2;

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R10
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|status) |=> irq_out);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|status) |=> !irq_out);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw & ~$past(en)) == '0);

  // R6
  level_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n || cyc != 2'd3)
    ((raw ^ ~($past(pin_lvl) ^ $past(pol))) & $past(en & ~edg & ~any)) == '0);

  // R5
  any_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || cyc != 2'd3)
    (($past(pin_lvl) ^ $past(pin_lvl, 2)) & $past(any & en) & ~raw) == '0);

  // R2
  lane_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(8'h10)) |=>
      en[H-1:0] == (($past(en[H-1:0]) & ~$past(bus_wdata[NPINS-1:H]))
                   | ($past(bus_wdata[H-1:0]) & $past(bus_wdata[NPINS-1:H]))));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_lvl   (pin_lvl),
  .en        (en_q),
  .edg       (edg_q),
  .pol       (pol_q),
  .any       (any_q),
  .raw       (raw_w),
  .status    (status_w),
  .irq_out   (irq_out)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_lvl;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  gpio_irq_detect uut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // Behavioural reference model
  logic [31:0] m_en, m_msk, m_edg, m_pol, m_any, m_raw, m_prev, m_ack, m_nraw;
  logic        m_irq;

  function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] wd,
                                        input logic hi);
    logic [31:0] r = cur;
    for (int b = 0; b < 16; b++) if (wd[16+b]) r[(hi ? 16 : 0) + b] = wd[b];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_msk = '0; m_edg = '0; m_pol = '0; m_any = '0;
      m_raw = '0; m_prev = '0; m_irq = 1'b0;
    end else begin
      m_ack = '0;
      if (bus_wr && bus_addr == 8'h60) m_ack[15:0]  = bus_wdata[31:16] & bus_wdata[15:0];
      if (bus_wr && bus_addr == 8'h64) m_ack[31:16] = bus_wdata[31:16] & bus_wdata[15:0];
      for (int i = 0; i < 32; i++) begin
        bit r, f, h;
        r = pin_lvl[i] && !m_prev[i];
        f = !pin_lvl[i] && m_prev[i];
        h = m_any[i] ? (r || f) : (m_pol[i] ? r : f);
        if (!m_en[i])                  m_nraw[i] = 1'b0;
        else if (m_edg[i] || m_any[i]) m_nraw[i] = (m_raw[i] && !m_ack[i]) || h;
        else                           m_nraw[i] = (pin_lvl[i] == m_pol[i]);
      end
      m_irq  = |(m_raw & ~m_msk);
      m_raw  = m_nraw;
      m_prev = pin_lvl;
      if (bus_wr && bus_addr[1:0] == 2'b00) begin
        case (bus_addr[7:3])
          5'h02: m_en  = merge(m_en,  bus_wdata, bus_addr[2]);
          5'h03: m_msk = merge(m_msk, bus_wdata, bus_addr[2]);
          5'h04: m_edg = merge(m_edg, bus_wdata, bus_addr[2]);
          5'h05: m_pol = merge(m_pol, bus_wdata, bus_addr[2]);
          5'h06: m_any = merge(m_any, bus_wdata, bus_addr[2]);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] w = '0;
    if (a[1:0] == 2'b00) begin
      case (a[7:3])
        5'h02: w = m_en;
        5'h03: w = m_msk;
        5'h04: w = m_edg;
        5'h05: w = m_pol;
        5'h06: w = m_any;
        5'h0A: w = m_raw & ~m_msk;
        5'h0B: w = m_raw;
        default: w = '0;
      endcase
    end
    return {16'h0, a[2] ? w[31:16] : w[15:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // R10: interrupt line compared against the model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) check(irq_out === m_irq, "R10 irq", {31'h0, irq_out}, {31'h0, m_irq});
  end

  task automatic rd(input logic [7:0] a, input string tag);
    logic [31:0] e;
    bus_addr = a;
    #1;
    e = exp_rd(a);
    check(bus_rdata === e, tag, bus_rdata, e);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; pin_lvl = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(3);
    // R1 reset state
    for (int a = 8'h10; a <= 8'h64; a += 4) rd(8'(a), "R1 reset read");
    check(irq_out === 1'b0, "R1 irq reset", {31'h0, irq_out}, 32'h0);
    rst_n = 1'b1;
    step(1);

    // R2 half-word writes and readback
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h10, "R2 enable lo"); rd(8'h14, "R2 enable hi");
    wr(8'h18, 32'h00F0_00A5);
    rd(8'h18, "R2 partial mask lo"); rd(8'h1C, "R2 mask hi untouched");
    wr(8'h18, 32'h00F0_0000);
    rd(8'h18, "R2 mask cleared");
    rd(8'h12, "R2 unaligned reads 0");
    rd(8'h40, "R2 unmapped reads 0");
    rd(8'h60, "R2 ack reads 0");

    // R3 rising, R4 falling
    wr(8'h20, 32'h00FF_00FF);
    wr(8'h28, 32'h000F_000F);
    rd(8'h58, "R6 level pins after setup");
    pin_lvl[0] = 1'b1; step(1);
    rd(8'h58, "R3 rising latched");
    pin_lvl[0] = 1'b0; step(2);
    rd(8'h58, "R3 stays latched after fall");
    pin_lvl[4] = 1'b1; step(2);
    rd(8'h58, "R4 rise ignored");
    pin_lvl[4] = 1'b0; step(1);
    rd(8'h58, "R4 falling latched");

    // R7 end-of-interrupt
    wr(8'h60, 32'h0000_0011);
    rd(8'h58, "R7 ack without enable ignored");
    wr(8'h60, 32'h0011_0011);
    rd(8'h58, "R7 ack clears edges");
    @(negedge clk);
    pin_lvl[1] = 1'b1; bus_wr = 1'b1; bus_addr = 8'h60; bus_wdata = 32'h0002_0002;
    @(negedge clk); bus_wr = 1'b0;
    rd(8'h58, "R7 same-cycle edge wins");

    // R5 any-edge on pin 16 (level sense, polarity 0)
    rd(8'h5C, "R6 pin16 level active low");
    wr(8'h34, 32'h0001_0001);
    wr(8'h64, 32'h0001_0001);
    rd(8'h5C, "R5 cleared after ack");
    pin_lvl[16] = 1'b1; step(1);
    rd(8'h5C, "R5 rise latched");
    wr(8'h64, 32'h0001_0001);
    pin_lvl[16] = 1'b0; step(1);
    rd(8'h5C, "R5 fall latched");

    // R6 level pin 8 active high
    wr(8'h28, 32'h0100_0100);
    pin_lvl[8] = 1'b1; step(1);
    rd(8'h58, "R6 level high seen");
    wr(8'h60, 32'h0100_0100);
    rd(8'h58, "R7 ack has no effect on level");
    pin_lvl[8] = 1'b0; step(1);
    rd(8'h58, "R6 level follows pin");

    // R9 mask
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h50, "R9 status masked lo"); rd(8'h58, "R9 raw ignores mask");
    rd(8'h54, "R9 status masked hi"); rd(8'h5C, "R9 raw hi");
    step(2);
    check(irq_out === 1'b0, "R10 irq off when all masked", {31'h0, irq_out}, 32'h0);
    wr(8'h18, 32'hFFFF_0000); wr(8'h1C, 32'hFFFF_0000);

    // R8 disable
    wr(8'h10, 32'h0001_0000);
    rd(8'h58, "R8 disable drops raw");
    pin_lvl[0] = 1'b1; step(2);
    rd(8'h58, "R8 disabled pin records nothing");

    // Random phase
    for (int it = 0; it < 600; it++) begin
      pin_lvl = pin_lvl ^ ($urandom & $urandom);
      if (($urandom % 3) == 0) begin
        logic [7:0] a;
        a = 8'(8'h10 + 4 * ($urandom % 10));
        if (($urandom % 4) == 0) a = {7'h30, 1'b0} | 8'(4 * ($urandom % 2));
        wr(a, $urandom);
      end else begin
        step(1);
      end
      rd(8'h50, "R9 random status lo"); rd(8'h54, "R9 random status hi");
      rd(8'h58, "R3 random raw lo");    rd(8'h5C, "R4 random raw hi");
    end
    step(2);
    summary();
  end

endmodule